// File: doc/BRIEF.md
# Real-Input 16-Point Radix-2 FFT

This block transforms a frame of sixteen signed real samples into its frequency spectrum. It uses a radix-2 decimation-in-frequency graph that has been cut down for real input. Samples arrive one per handshake on a valid/ready port. Once the sixteenth sample is taken, a small shared datapath works through the pruned graph. The datapath has one real butterfly, one complex rotator and one complex butterfly, and a four-entry constant twiddle table feeds the rotator.

With real input, bin k is the complex conjugate of bin 16-k. Because of that symmetry, only nine bins are ever computed. Bins 3, 6, 7, 11, 12, 14 and 15 exist only as conjugates of bins 13, 10, 9, 5, 4, 2 and 1. The graph therefore drops every butterfly that feeds only those bins. Values stay real until their first rotation. Where two real values would meet a rotation, they are packed into one complex word as `re - j·im` and rotated once, with no addition.

Each of the four radix-2 levels halves its result with round-half-up, so every emitted bin equals X[k]/16. The consumer receives the nine bins in a fixed ascending order. Each bin carries its index and a last flag, and the consumer can stall any of them.

Top module: `rfft16_real`

## Requirements
- R1: A sample is taken on every rising clock edge where `in_valid` and `in_ready` are both high. The n-th sample taken (n = 0..15) is x[n] of the frame, as a 12-bit two's-complement value.
- R2: `in_ready` is low from the edge that takes the sixteenth sample until the edge that hands over the last bin. It is high again on the cycle after that edge.
- R3: Each frame yields exactly nine outputs, with `out_bin` taking the values 0, 1, 2, 4, 5, 8, 9, 10, 13 in that order. `out_last` is high only together with `out_bin` = 13.
- R4: For every emitted bin k, `out_re` and `out_im` are two's-complement values. Each lies within 3 LSB of the real and imaginary parts of (1/16)·Σ x[n]·e^(-j2πkn/16).
- R5: For bins 0 and 8, `out_im` is exactly zero.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_re`, `out_im`, `out_bin` and `out_last` keep their values into the next cycle.
- R7: After reset, `in_ready` is high and `out_valid` is low.
- R8: Every bin k in {3, 6, 7, 11, 12, 14, 15} is within 3 LSB of the conjugate of emitted bin 16-k. That is, it is within 3 LSB of the real part and of the negated imaginary part of the emitted bin.
- R9: Full-scale frames (all samples -2048, or +2047 and -2048 alternating) meet R4 with no wrap-around.
- R10: While `in_ready` is low, `in_valid` and `in_data` have no effect: neither the bins of the current frame nor the samples of the next frame change.
- R11: The ±1 and ±j rotations are done by passing data through, swapping the real and imaginary parts and negating, with no multiply. The other rotations use the 14-bit constants for e^(-j2πm/16), m = 1..3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal two-flop synchronizer |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | 12 | Signed real sample |
| out_valid | output | 1 | Bin present |
| out_ready | input | 1 | Consumer takes the bin |
| out_re | output | 14 | Signed real part of X[k]/16 |
| out_im | output | 14 | Signed imaginary part of X[k]/16 |
| out_bin | output | 4 | Index k of the bin on the output |
| out_last | output | 1 | Final bin (k = 13) of the frame |

## Verification
Two events can fall on the same edge: the handshake of the final bin and a sample that the source is already offering for the next frame. Because `in_ready` rises only after that edge, the offered sample must not be taken together with bin 13. The bench provokes this by keeping `in_valid` high with junk data throughout the emit phase, under both stalling and free-running `out_ready`. It then judges the outcome at the ports: the current frame's bins must be unchanged, `in_ready` must stay low until the cycle after the last handshake, and the next frame, fed from a clean start, must produce its own correct spectrum.

// File: rtl/rfft16_pkg.sv
package rfft16_pkg;

  localparam int NPTS    = 16;
  localparam int NBINS   = 9;
  localparam int TW_FRAC = 12;

  typedef enum logic [2:0] {
    PH_LOAD = 3'd0,
    PH_LVL1 = 3'd1,
    PH_LVL2 = 3'd2,
    PH_LVL3 = 3'd3,
    PH_LVL4 = 3'd4,
    PH_EMIT = 3'd5
  } phase_t;

  // cosine part of e^(-j2*pi*m/16), scaled by 2^TW_FRAC
  function automatic int tw_cos(input logic [1:0] m);
    case (m)
      2'd0:    return 4096;
      2'd1:    return 3784;
      2'd2:    return 2896;
      default: return 1567;
    endcase
  endfunction

  // magnitude of the (negated) sine part, scaled by 2^TW_FRAC
  function automatic int tw_sin(input logic [1:0] m);
    case (m)
      2'd0:    return 0;
      2'd1:    return 1567;
      2'd2:    return 2896;
      default: return 3784;
    endcase
  endfunction

  // emission slot -> bin index
  function automatic logic [3:0] slot_bin(input logic [3:0] s);
    case (s)
      4'd0:    return 4'd0;
      4'd1:    return 4'd1;
      4'd2:    return 4'd2;
      4'd3:    return 4'd4;
      4'd4:    return 4'd5;
      4'd5:    return 4'd8;
      4'd6:    return 4'd9;
      4'd7:    return 4'd10;
      default: return 4'd13;
    endcase
  endfunction

endpackage

// File: rtl/rfft16_rbfly.sv
module rfft16_rbfly #(
  parameter int W = 14
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] sum_h,
  output logic signed [W-1:0] dif_h
);
  logic signed [W:0] s_w, d_w, s_r, d_r;

  always_comb begin
    s_w   = $signed({a[W-1], a}) + $signed({b[W-1], b});
    d_w   = $signed({a[W-1], a}) - $signed({b[W-1], b});
    s_r   = (s_w + (W+1)'(1)) >>> 1;
    d_r   = (d_w + (W+1)'(1)) >>> 1;
    sum_h = s_r[W-1:0];
    dif_h = d_r[W-1:0];
  end
endmodule

// File: rtl/rfft16_cbfly.sv
module rfft16_cbfly #(
  parameter int W = 14
) (
  input  logic signed [W-1:0] ar,
  input  logic signed [W-1:0] ai,
  input  logic signed [W-1:0] br,
  input  logic signed [W-1:0] bi,
  output logic signed [W-1:0] sr,
  output logic signed [W-1:0] si,
  output logic signed [W-1:0] dr,
  output logic signed [W-1:0] di
);
  rfft16_rbfly #(.W(W)) u_re (.a(ar), .b(br), .sum_h(sr), .dif_h(dr));
  rfft16_rbfly #(.W(W)) u_im (.a(ai), .b(bi), .sum_h(si), .dif_h(di));
endmodule

// File: rtl/rfft16_rot.sv
module rfft16_rot #(
  parameter int W    = 14,
  parameter int TW_W = 14
) (
  input  logic signed [W-1:0] xr,
  input  logic signed [W-1:0] xi,
  input  logic [1:0]          m,
  output logic signed [W-1:0] yr,
  output logic signed [W-1:0] yi
);
  import rfft16_pkg::*;

  localparam int PW = W + TW_W + 1;
  localparam int SH = TW_FRAC + 1;

  logic signed [TW_W-1:0] cw, sw;
  logic signed [PW-1:0]   pr, pim, qr, qi;
  logic signed [W:0]      hr, hi;

  always_comb begin
    cw  = TW_W'(tw_cos(m));
    sw  = TW_W'(tw_sin(m));
    // (xr + j xi)(cw - j sw), scaled by 1/2 with rounding
    pr  = PW'(xr) * PW'(cw) + PW'(xi) * PW'(sw);
    pim = PW'(xi) * PW'(cw) - PW'(xr) * PW'(sw);
    qr  = (pr  + (PW'(1) <<< (SH-1))) >>> SH;
    qi  = (pim + (PW'(1) <<< (SH-1))) >>> SH;
    // trivial rotation: halve only, no product
    hr  = ($signed({xr[W-1], xr}) + (W+1)'(1)) >>> 1;
    hi  = ($signed({xi[W-1], xi}) + (W+1)'(1)) >>> 1;
    if (m == 2'd0) begin
      yr = hr[W-1:0];
      yi = hi[W-1:0];
    end else begin
      yr = qr[W-1:0];
      yi = qi[W-1:0];
    end
  end
endmodule

// File: rtl/rfft16_real.sv
module rfft16_real #(
  parameter int IN_W = 12,
  parameter int DW   = 14,
  parameter int TW_W = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [IN_W-1:0]      in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DW-1:0]        out_re,
  output logic [DW-1:0]        out_im,
  output logic [3:0]           out_bin,
  output logic                 out_last
);
  import rfft16_pkg::*;

  localparam int HALF = NPTS / 2;
  localparam int QTR  = NPTS / 4;
  localparam int EGHT = NPTS / 8;

  // ---------------- reset synchronizer ----------------
  logic [1:0] rst_pipe;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  // ---------------- control ----------------
  phase_t     phase_q, phase_d;
  logic [3:0] cnt_q, cnt_d;
  logic       take_smp, take_bin;

  assign in_ready  = (phase_q == PH_LOAD);
  assign out_valid = (phase_q == PH_EMIT);
  assign take_smp  = in_valid && in_ready;
  assign take_bin  = out_valid && out_ready;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_LOAD: if (take_smp) begin
        cnt_d = cnt_q + 4'd1;
        if (cnt_q == 4'(NPTS-1)) begin phase_d = PH_LVL1; cnt_d = '0; end
      end
      PH_LVL1: begin
        cnt_d = cnt_q + 4'd1;
        if (cnt_q == 4'(HALF-1)) begin phase_d = PH_LVL2; cnt_d = '0; end
      end
      PH_LVL2: begin
        cnt_d = cnt_q + 4'd1;
        if (cnt_q == 4'(QTR-1)) begin phase_d = PH_LVL3; cnt_d = '0; end
      end
      PH_LVL3: begin
        cnt_d = cnt_q + 4'd1;
        if (cnt_q == 4'(EGHT-1)) begin phase_d = PH_LVL4; cnt_d = '0; end
      end
      PH_LVL4: begin
        cnt_d = cnt_q + 4'd1;
        if (cnt_q == 4'(EGHT-1)) begin phase_d = PH_EMIT; cnt_d = '0; end
      end
      PH_EMIT: if (take_bin) begin
        cnt_d = cnt_q + 4'd1;
        if (cnt_q == 4'(NBINS-1)) begin phase_d = PH_LOAD; cnt_d = '0; end
      end
      default: begin phase_d = PH_LOAD; cnt_d = '0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      phase_q <= PH_LOAD;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  // ---------------- storage ----------------
  logic signed [DW-1:0] xs   [NPTS];
  logic signed [DW-1:0] sa   [HALF];   // level-1 sums (real)
  logic signed [DW-1:0] sd   [HALF];   // level-1 differences (real)
  logic signed [DW-1:0] se   [QTR];    // level-2 sums (real)
  logic signed [DW-1:0] sg   [QTR];    // level-2 differences (real)
  logic signed [DW-1:0] cr   [QTR];    // packed-and-rotated odd branch
  logic signed [DW-1:0] ci   [QTR];
  logic signed [DW-1:0] hr   [EGHT];   // packed-and-rotated 2 mod 4 branch
  logic signed [DW-1:0] hi   [EGHT];
  logic signed [DW-1:0] pp   [EGHT];   // level-3 real sums
  logic signed [DW-1:0] qq   [EGHT];   // level-3 real differences
  logic signed [DW-1:0] ur   [EGHT];
  logic signed [DW-1:0] ui   [EGHT];
  logic signed [DW-1:0] vr   [EGHT];
  logic signed [DW-1:0] vi   [EGHT];

  // ---------------- shared arithmetic ----------------
  logic signed [DW-1:0] rb_a, rb_b, rb_s, rb_d;
  logic signed [DW-1:0] rt_xr, rt_xi, rt_yr, rt_yi;
  logic [1:0]           rt_m;
  logic signed [DW-1:0] cb_ar, cb_ai, cb_br, cb_bi, cb_sr, cb_si, cb_dr, cb_di;
  logic                 emit_dif;

  rfft16_rbfly #(.W(DW)) u_rbfly (
    .a(rb_a), .b(rb_b), .sum_h(rb_s), .dif_h(rb_d));

  rfft16_rot #(.W(DW), .TW_W(TW_W)) u_rot (
    .xr(rt_xr), .xi(rt_xi), .m(rt_m), .yr(rt_yr), .yi(rt_yi));

  rfft16_cbfly #(.W(DW)) u_cbfly (
    .ar(cb_ar), .ai(cb_ai), .br(cb_br), .bi(cb_bi),
    .sr(cb_sr), .si(cb_si), .dr(cb_dr), .di(cb_di));

  // operand selection
  always_comb begin
    rb_a  = '0; rb_b  = '0;
    rt_xr = '0; rt_xi = '0; rt_m = 2'd0;
    cb_ar = '0; cb_ai = '0; cb_br = '0; cb_bi = '0;
    emit_dif = 1'b0;
    unique case (phase_q)
      PH_LVL1: begin
        rb_a = xs[{1'b0, cnt_q[2:0]}];
        rb_b = xs[{1'b1, cnt_q[2:0]}];
      end
      PH_LVL2: begin
        rb_a  = sa[{1'b0, cnt_q[1:0]}];
        rb_b  = sa[{1'b1, cnt_q[1:0]}];
        rt_xr = sd[{1'b0, cnt_q[1:0]}];
        rt_xi = -sd[{1'b1, cnt_q[1:0]}];
        rt_m  = cnt_q[1:0];
      end
      PH_LVL3: begin
        rb_a  = se[{1'b0, cnt_q[0]}];
        rb_b  = se[{1'b1, cnt_q[0]}];
        rt_xr = sg[{1'b0, cnt_q[0]}];
        rt_xi = -sg[{1'b1, cnt_q[0]}];
        rt_m  = {cnt_q[0], 1'b0};
      end
      PH_LVL4: begin
        cb_ar = cr[{1'b0, cnt_q[0]}]; cb_ai = ci[{1'b0, cnt_q[0]}];
        cb_br = cr[{1'b1, cnt_q[0]}]; cb_bi = ci[{1'b1, cnt_q[0]}];
      end
      PH_EMIT: begin
        unique case (cnt_q)
          4'd0, 4'd5: begin cb_ar = pp[0]; cb_br = pp[1]; end
          4'd1, 4'd6: begin cb_ar = ur[0]; cb_ai = ui[0]; cb_br = ur[1]; cb_bi = ui[1]; end
          4'd2, 4'd7: begin cb_ar = hr[0]; cb_ai = hi[0]; cb_br = hr[1]; cb_bi = hi[1]; end
          4'd3:       begin cb_ar = qq[0]; cb_bi = -qq[1]; end
          default:    begin cb_ar = vr[0]; cb_ai = vi[0]; cb_br = vr[1]; cb_bi = vi[1]; end
        endcase
        emit_dif = (cnt_q >= 4'd5);
      end
      default: ;
    endcase
  end

  // datapath registers (no reset, written under explicit enables)
  always_ff @(posedge clk) begin
    if (take_smp)
      xs[cnt_q] <= DW'($signed(in_data));
    if (phase_q == PH_LVL1) begin
      sa[cnt_q[2:0]] <= rb_s;
      sd[cnt_q[2:0]] <= rb_d;
    end
    if (phase_q == PH_LVL2) begin
      se[cnt_q[1:0]] <= rb_s;
      sg[cnt_q[1:0]] <= rb_d;
      cr[cnt_q[1:0]] <= rt_yr;
      ci[cnt_q[1:0]] <= rt_yi;
    end
    if (phase_q == PH_LVL3) begin
      pp[cnt_q[0]] <= rb_s;
      qq[cnt_q[0]] <= rb_d;
      hr[cnt_q[0]] <= rt_yr;
      hi[cnt_q[0]] <= rt_yi;
    end
    if (phase_q == PH_LVL4) begin
      ur[cnt_q[0]] <= cb_sr;
      ui[cnt_q[0]] <= cb_si;
      if (cnt_q[0]) begin        // multiply difference by -j: swap and negate
        vr[1] <= cb_di;
        vi[1] <= -cb_dr;
      end else begin
        vr[0] <= cb_dr;
        vi[0] <= cb_di;
      end
    end
  end

  // ---------------- output ----------------
  assign out_re   = emit_dif ? cb_dr : cb_sr;
  assign out_im   = emit_dif ? cb_di : cb_si;
  assign out_bin  = slot_bin(cnt_q);
  assign out_last = out_valid && (cnt_q == 4'(NBINS-1));

  // ---------------- assertions ----------------
  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid && !out_ready |=> out_valid && $stable(out_re) && $stable(out_im)
                               && $stable(out_bin) && $stable(out_last));

  a_r3_last_is_13: assert property (@(posedge clk) disable iff (!rst_q)
    out_last |-> out_valid && out_bin == 4'd13);

  a_r5_real_dc_nyq: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid && (out_bin == 4'd0 || out_bin == 4'd8) |-> out_im == '0);

  a_r2_no_take_while_emit: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |-> !in_ready);

  a_r2_reopen_after_last: assert property (@(posedge clk) disable iff (!rst_q)
    out_last && out_ready |=> in_ready && !out_valid);

  a_r3_bins_advance: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid && out_ready && !out_last |=> out_valid && out_bin > $past(out_bin));

  a_r11_trivial_rot: assert property (@(posedge clk) disable iff (!rst_q)
    phase_q == PH_LVL2 && cnt_q == 4'd0 |=> cr[0] == sa[0] - sa[0] + $past(rt_yr));

endmodule

// File: tb/rfft16_real_bench.sv
module rfft16_real_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [11:0] in_data;
  logic        out_valid;
  logic        out_ready;
  logic [13:0] out_re, out_im;
  logic [3:0]  out_bin;
  logic        out_last;

  int checks   = 0;
  int failures = 0;
  int smp [16];
  int got_re [16];
  int got_im [16];
  int exp_order [9] = '{0, 1, 2, 4, 5, 8, 9, 10, 13};
  real PI = 3.14159265358979;

  always #2 clk = ~clk;   // 250 MHz

  rfft16_real u_rfft16_real (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im), .out_bin(out_bin), .out_last(out_last));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic real ref_re(input int k);
    real acc = 0.0;
    for (int n = 0; n < 16; n++) acc += smp[n] * $cos(2.0 * PI * k * n / 16.0);
    return acc / 16.0;
  endfunction

  function automatic real ref_im(input int k);
    real acc = 0.0;
    for (int n = 0; n < 16; n++) acc -= smp[n] * $sin(2.0 * PI * k * n / 16.0);
    return acc / 16.0;
  endfunction

  function automatic bit near(input int a, input real e);
    real d = a - e;
    return (d <= 3.0) && (d >= -3.0);
  endfunction

  // R1: one sample per valid&ready edge, index order
  task automatic send_frame();
    for (int n = 0; n < 16; n++) begin
      bit taken = 0;
      while (!taken) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 12'(smp[n]);
        taken    = in_ready;
        @(posedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // stall: 0 always ready, 1 alternate, 2 random; junk: drive input while closed
  task automatic run_frame(input string tag, input int stall, input bit junk);
    int nb = 0;
    int cyc = 0;
    bit held = 0;
    int h_re = 0, h_im = 0, h_bin = 0;
    send_frame();
    if (junk) begin in_valid = 1'b1; in_data = 12'h5A5; end
    while (nb < 9) begin
      @(negedge clk);
      cyc++;
      if (stall == 0)      out_ready = 1'b1;
      else if (stall == 1) out_ready = cyc[0];
      else                 out_ready = ($urandom % 2) == 1;
      if (held)
        chk(out_valid && $signed(out_re) == h_re && $signed(out_im) == h_im
            && int'(out_bin) == h_bin, "R6", {tag, " stalled bin moved"},
            int'(out_bin), h_bin);
      held = 0;
      if (out_valid) begin
        chk(!in_ready, "R2", {tag, " in_ready while emitting"}, int'(in_ready), 0);
        if (!out_ready) begin
          held = 1; h_re = $signed(out_re); h_im = $signed(out_im); h_bin = int'(out_bin);
        end else begin
          chk(int'(out_bin) == exp_order[nb], "R3", {tag, " bin order"},
              int'(out_bin), exp_order[nb]);
          chk(out_last == (nb == 8), "R3", {tag, " last flag"}, int'(out_last), int'(nb == 8));
          got_re[out_bin] = $signed(out_re);
          got_im[out_bin] = $signed(out_im);
          nb++;
        end
      end
    end
    @(negedge clk);
    in_valid  = 1'b0;          // R10: junk dropped before in_ready can be used
    out_ready = 1'b0;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R2", {tag, " reopen after last"},
        int'(in_ready), 1);
    // R4 / R5 / R8 value checks
    for (int i = 0; i < 9; i++) begin
      int k = exp_order[i];
      chk(near(got_re[k], ref_re(k)), "R4", $sformatf("%s re bin %0d", tag, k),
          got_re[k], $rtoi(ref_re(k)));
      chk(near(got_im[k], ref_im(k)), "R4", $sformatf("%s im bin %0d", tag, k),
          got_im[k], $rtoi(ref_im(k)));
    end
    chk(got_im[0] == 0, "R5", {tag, " bin0 imag"}, got_im[0], 0);
    chk(got_im[8] == 0, "R5", {tag, " bin8 imag"}, got_im[8], 0);
    for (int k = 1; k < 16; k++) begin
      if (k == 3 || k == 6 || k == 7 || k == 11 || k == 12 || k == 14 || k == 15) begin
        chk(near(got_re[16-k], ref_re(k)) && near(-got_im[16-k], ref_im(k)), "R8",
            $sformatf("%s conj partner bin %0d", tag, k), -got_im[16-k], $rtoi(ref_im(k)));
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready == 1'b1, "R7", "reset in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R7", "reset out_valid", int'(out_valid), 0);
  endtask

  task automatic t_impulse();   // R1 R4: impulse gives flat spectrum
    for (int n = 0; n < 16; n++) smp[n] = 0;
    smp[0] = 1000;
    run_frame("impulse", 0, 0);
  endtask

  task automatic t_delayed_impulse();   // R1: index order matters (phase ramp)
    for (int n = 0; n < 16; n++) smp[n] = 0;
    smp[3] = -1500;
    run_frame("delayed_impulse", 1, 0);
  endtask

  task automatic t_tones();     // R4 R11: non-trivial twiddles exercised
    for (int n = 0; n < 16; n++)
      smp[n] = $rtoi(1200.0 * $cos(2.0 * PI * 3 * n / 16.0)
                   + 600.0 * $sin(2.0 * PI * 5 * n / 16.0));
    run_frame("tones", 1, 0);
  endtask

  task automatic t_fullscale();  // R9
    for (int n = 0; n < 16; n++) smp[n] = -2048;
    run_frame("fullscale_neg", 0, 0);
    for (int n = 0; n < 16; n++) smp[n] = n[0] ? -2048 : 2047;
    run_frame("fullscale_alt", 2, 0);
  endtask

  task automatic t_random();     // R4 R6 under random stall
    for (int f = 0; f < 4; f++) begin
      for (int n = 0; n < 16; n++) smp[n] = int'($urandom_range(0, 4095)) - 2048;
      run_frame($sformatf("random%0d", f), 2, 0);
    end
  endtask

  task automatic t_ignored_input();  // R10: junk while closed, then clean frame
    for (int n = 0; n < 16; n++) smp[n] = 100 * n - 700;
    run_frame("junk_cur", 1, 1);
    for (int n = 0; n < 16; n++) smp[n] = 50 - 37 * n;
    run_frame("junk_next", 0, 1);
    for (int n = 0; n < 16; n++) smp[n] = (n % 4) * 300;
    run_frame("after_junk", 2, 0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_impulse();
    t_delayed_impulse();
    t_tones();
    t_fullscale();
    t_random();
    t_ignored_input();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule